// File: doc/BRIEF.md
# Solid and Checkerboard Pattern Memory Tester

This block is a self-test sequencer for a single-bit-wide memory of N cells, organised as 2^ROW_W rows by 2^COL_W columns. Once started, it writes a data background into every cell and reads it back. It then writes the complementary background and reads that back too, comparing every read against the value it expects. Two backgrounds are offered. The solid mode uses all zeros followed by all ones. The checkerboard mode uses a pattern in which every cell differs from its horizontal and vertical neighbours, followed by the inverse of that pattern.

The tester owns the memory's address, write enable, read enable and write data lines while a test runs. It expects read data one clock after a read request, which suits a memory with a registered output. The first mismatch latches its address and raises a fail flag. The test still runs to the end, so the total operation count and the test time do not depend on the memory's health. A one-cycle done pulse marks the moment the verdict is final.

Top module: `mem_pattern_tester`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o, fail_o, mem_we_o and mem_re_o are 0 and fail_addr_o is 0. A start held during reset has no effect.
- R2: With mode_i = 0 (solid), the test runs four passes in this order: write 0, read expecting 0, write 1, read expecting 1.
- R3: With mode_i = 1 (checkerboard), the address is {row, col}, with the row in the upper ROW_W bits. The background bit is row[0] XOR col[0]. Passes 0 and 1 write and read that bit. Passes 2 and 3 write and read its complement.
- R4: Every pass visits addresses 0 to N-1 in ascending order, one operation per cycle. The first operation appears in the cycle after the start is sampled. A test issues exactly 4N operations, and busy_o stays high for 4N+1 cycles.
- R5: Read data is compared one cycle after its read request. A mismatch sets fail_o.
- R6: fail_addr_o holds the address of the first mismatch. Later mismatches change neither fail_o nor fail_addr_o, and the test still runs to completion.
- R7: done_o is a single-cycle pulse, 4N+1 cycles after the edge that samples start. fail_o and fail_addr_o hold their values after done until the next accepted start.
- R8: start_i is ignored while busy_o is high. mode_i is sampled only when a start is accepted.
- R9: An accepted start clears fail_o and fail_addr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a test when idle |
| mode_i | input | 1 | 0 = solid backgrounds, 1 = checkerboard |
| mem_addr_o | output | ROW_W+COL_W | Memory address {row, col} |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | 1 | Memory write data |
| mem_rdata_i | input | 1 | Memory read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | At least one mismatch seen |
| fail_addr_o | output | ROW_W+COL_W | Address of the first mismatch |

## Verification
Operation k of a test, counted from zero, is due in the cycle after edge k, where edge 0 is the edge that samples start. The bench samples the memory lines at the falling edge after each of those rising edges. It compares them with the pass and address that k implies: pass k/N, address k mod N. The final read lands at edge 4N, and its compare result reaches fail_o at edge 4N+1, together with done_o. The bench therefore checks the verdict at the falling edge after edge 4N+1, and checks one cycle later that done has dropped while the verdict still holds. Fail clearing after a start is checked at the falling edge after edge 0.

// File: rtl/mem_pattern_tester_pkg.sv
`timescale 1ns/1ps
// Shared types for the pattern memory tester.
package mem_pattern_tester_pkg;
    typedef enum logic {
        PAT_SOLID   = 1'b0,
        PAT_CHECKER = 1'b1
    } pat_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    localparam int PASS_W = 2;  // four passes: write, read, write, read
endpackage

// File: rtl/mpt_sequencer.sv
`timescale 1ns/1ps
// Walks four ascending passes over all addresses, one operation per cycle.
// Pass bit 0 selects read (1) or write (0), and pass bit 1 selects the
// inverted background. One drain cycle follows the last read so that its
// compare can complete; a single-cycle done pulse follows the drain.
// Assumes start is a synchronous level sampled only while idle.
module mpt_sequencer
    import mem_pattern_tester_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              accept_o,
    output logic              run_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [PASS_W-1:0] pass_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [PASS_W-1:0] LAST_PASS = {PASS_W{1'b1}};

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PASS_W-1:0] pass_q;
    logic              done_q;
    logic              end_of_pass;

    assign accept_o    = start_i && (state_q == ST_IDLE);
    assign end_of_pass = (addr_q == LAST_ADDR);

    // State, address and pass counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            pass_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        state_q <= ST_RUN;
                        addr_q  <= '0;
                        pass_q  <= '0;
                    end
                end
                ST_RUN: begin
                    addr_q <= addr_q + 1'b1;
                    if (end_of_pass) begin
                        pass_q <= pass_q + 1'b1;
                        if (pass_q == LAST_PASS) state_q <= ST_DRAIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse, one cycle after the drain cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_DRAIN);
    end

    assign run_o  = (state_q == ST_RUN);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign pass_o = pass_q;
    assign addr_o = addr_q;

    // R4: within a pass the address advances by exactly one each cycle
    a_r4_ascending_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !end_of_pass) |=>
            (state_q == ST_RUN && addr_q == $past(addr_q) + 1'b1));

    // R4: the last operation of the last pass is followed by the drain cycle
    a_r4_drain_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && end_of_pass && pass_q == LAST_PASS) |=>
            (state_q == ST_DRAIN));

    // R7: done never lasts more than one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/mpt_pattern.sv
`timescale 1ns/1ps
// Computes the expected background bit for an address and pass.
// Solid mode: 0 in passes 0-1, 1 in passes 2-3.
// Checkerboard mode: row LSB XOR column LSB, complemented in passes 2-3.
// Assumes the address is {row, col}, with the column in the low COL_W bits.
module mpt_pattern
    import mem_pattern_tester_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  pat_mode_e                 mode_i,
    input  logic [PASS_W-1:0]         pass_i,
    input  logic [ROW_W+COL_W-1:0]    addr_i,
    output logic                      bit_o
);
    logic parity;

    // Parity of row LSB and column LSB gives alternation in both directions.
    always_comb begin
        parity = addr_i[COL_W] ^ addr_i[0];
        bit_o  = ((mode_i == PAT_CHECKER) ? parity : 1'b0) ^ pass_i[1];
    end
endmodule

// File: rtl/mpt_compare.sv
`timescale 1ns/1ps
// Compares read data one cycle after each read request and keeps the
// address of the first mismatch. Assumes the memory returns read data in
// the cycle after mem_re. clr_i clears the verdict at the start of a test.
module mpt_compare #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rd_issue_i,
    input  logic              exp_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rdata_i,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o
);
    logic              chk_q;
    logic              exp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fail_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              mismatch;

    assign mismatch = chk_q && (rdata_i != exp_q);

    // Delay the read request, its expected bit and its address to data time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q  <= 1'b0;
            exp_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            chk_q  <= rd_issue_i;
            exp_q  <= exp_i;
            addr_q <= addr_i;
        end
    end

    // Sticky verdict capturing only the first failing address.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else if (mismatch && !fail_q) begin
            fail_q      <= 1'b1;
            fail_addr_q <= addr_q;
        end
    end

    assign fail_o      = fail_q;
    assign fail_addr_o = fail_addr_q;

    // R6: once set, the verdict and its address are frozen until cleared
    a_r6_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clr_i) |=> (fail_q && $stable(fail_addr_q)));

    // R5: a mismatching read always produces a fail
    a_r5_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q && (rdata_i != exp_q) && !clr_i) |=> fail_q);
endmodule

// File: rtl/mem_pattern_tester.sv
`timescale 1ns/1ps
// Memory self-test controller running either a solid (zero-one) or a
// checkerboard test, each as four ascending passes of 4N operations total.
// Assumes a single-bit-wide memory of 2^(ROW_W+COL_W) cells with a
// one-cycle read latency, owned exclusively by this block while busy.
module mem_pattern_tester
    import mem_pattern_tester_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 3,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              mem_wdata_o,
    input  logic              mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o
);
    logic              accept;
    logic              run;
    logic [PASS_W-1:0] pass;
    logic [ADDR_W-1:0] addr;
    logic              exp_bit;
    pat_mode_e         mode_q;

    // Mode is captured once per test, at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= PAT_SOLID;
        else if (accept) mode_q <= pat_mode_e'(mode_i);
    end

    mpt_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .run_o    (run),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .pass_o   (pass),
        .addr_o   (addr)
    );

    mpt_pattern #(.ROW_W(ROW_W), .COL_W(COL_W)) u_pat (
        .mode_i (mode_q),
        .pass_i (pass),
        .addr_i (addr),
        .bit_o  (exp_bit)
    );

    mpt_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (accept),
        .rd_issue_i  (mem_re_o),
        .exp_i       (exp_bit),
        .addr_i      (addr),
        .rdata_i     (mem_rdata_i),
        .fail_o      (fail_o),
        .fail_addr_o (fail_addr_o)
    );

    assign mem_addr_o  = addr;
    assign mem_we_o    = run && !pass[0];
    assign mem_re_o    = run &&  pass[0];
    assign mem_wdata_o = exp_bit;

    // R8: the captured mode cannot change while a test runs
    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mode_q));

    // R5: every read is compared while the tester is still busy
    a_r5_compare_in_test: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> busy_o);

    // R1: no memory access happens while idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_we_o && !mem_re_o));
endmodule

// File: tb/mem_pattern_tester_test.sv
`timescale 1ns/1ps
module mem_pattern_tester_test;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int NCELL  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we, mem_re, mem_wdata;
    logic              mem_rdata = 1'b0;
    logic              busy, done, fail;
    logic [ADDR_W-1:0] fail_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // fault injection: two stuck-at cells
    logic              f0_en = 1'b0, f0_val = 1'b0;
    logic [ADDR_W-1:0] f0_addr = '0;
    logic              f1_en = 1'b0, f1_val = 1'b0;
    logic [ADDR_W-1:0] f1_addr = '0;
    logic              cells [NCELL];

    mem_pattern_tester #(.ROW_W(ROW_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr)
    );

    always #4 clk = ~clk;

    // memory model with registered read and stuck-at faults
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_we) cells[mem_addr] <= mem_wdata;
        if (mem_re) begin
            if (f0_en && mem_addr == f0_addr)      mem_rdata <= f0_val;
            else if (f1_en && mem_addr == f1_addr) mem_rdata <= f1_val;
            else                                   mem_rdata <= cells[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic              md;
        logic              e0;
        logic [ADDR_W-1:0] a0;
        logic              v0;
        logic              e1;
        logic [ADDR_W-1:0] a1;
        logic              v1;
        logic              xfail;
        logic [ADDR_W-1:0] xaddr;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0 },  // solid clean
        '{1'b0, 1'b1, 6'd13, 1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 6'd13},  // solid stuck-1
        '{1'b0, 1'b1, 6'd40, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 6'd40},  // solid stuck-0
        '{1'b1, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 6'd0 },  // checker clean
        '{1'b1, 1'b1, 6'd9,  1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 6'd9 },  // checker stuck-0
        '{1'b1, 1'b1, 6'd1,  1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 6'd1 },  // checker stuck-1
        '{1'b0, 1'b1, 6'd20, 1'b1, 1'b1, 6'd5,  1'b1, 1'b1, 6'd5 },  // two faults
        '{1'b1, 1'b1, 6'd63, 1'b1, 1'b1, 6'd2,  1'b1, 1'b1, 6'd2 }   // two faults
    };

    // One full test; disturb pulses start and flips mode mid-run (R8).
    task automatic run_test(input vec_t v, input bit disturb);
        int op_err = 0;
        int ops = 0;
        int busy_cnt = 0;
        f0_en = v.e0; f0_addr = v.a0; f0_val = v.v0;
        f1_en = v.e1; f1_addr = v.a1; f1_val = v.v1;
        @(negedge clk);
        start = 1'b1; mode = v.md;
        @(negedge clk);
        start = 1'b0;
        // R9: verdict cleared by the accepted start
        check(fail == 1'b0 && fail_addr == '0, "R9", int'(fail), 0);
        for (int k = 0; k < 4 * NCELL; k++) begin
            int ph = k / NCELL;
            int ad = k % NCELL;
            bit xwr = (ph % 2) == 0;
            bit par = (v.md ? (ad[COL_W] ^ ad[0]) : 1'b0) ^ (ph >= 2);
            if (mem_we || mem_re) ops++;
            if (busy) busy_cnt++;
            if (mem_we != xwr || mem_re != !xwr || mem_addr != ADDR_W'(ad)) op_err++;
            if (xwr && mem_wdata != par) op_err++;
            if (disturb && k == 10) begin start = 1'b1; mode = ~v.md; end
            if (disturb && k == 11) start = 1'b0;
            @(negedge clk);
        end
        mode = v.md;
        if (v.md) check(op_err == 0, "R3", op_err, 0);
        else      check(op_err == 0, "R2", op_err, 0);
        if (disturb) check(op_err == 0, "R8", op_err, 0);
        // drain cycle: no operation, still busy
        if (busy) busy_cnt++;
        if (mem_we || mem_re) ops++;
        check(ops == 4 * NCELL, "R4", ops, 4 * NCELL);
        check(done == 1'b0, "R7", int'(done), 0);
        @(negedge clk);
        check(busy_cnt == 4 * NCELL + 1 && !busy, "R4", busy_cnt, 4 * NCELL + 1);
        check(done == 1'b1, "R7", int'(done), 1);
        check(fail == v.xfail, "R5", int'(fail), int'(v.xfail));
        check(fail_addr == v.xaddr, "R6", int'(fail_addr), int'(v.xaddr));
        @(negedge clk);
        check(done == 1'b0 && fail == v.xfail && fail_addr == v.xaddr,
              "R7", int'(fail_addr), int'(v.xaddr));
        f0_en = 1'b0; f1_en = 1'b0;
    endtask

    // watchdog
    initial begin
        wait (cycles > 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCELL; i++) cells[i] = 1'b0;
        // R1: reset state with start held during reset
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail && !mem_we && !mem_re && fail_addr == '0,
              "R1", int'(busy), 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1", int'(busy), 0);

        for (int i = 0; i < NVEC; i++) run_test(VECS[i], 1'b0);

        // R8: start pulse and mode change mid-run do not disturb the test
        run_test(VECS[1], 1'b1);
        run_test(VECS[4], 1'b1);
        // R9: clean run right after a failing one
        run_test(VECS[0], 1'b0);

        // R7: verdict holds while idle
        repeat (5) @(negedge clk);
        check(!busy && !done && !fail, "R7", int'(fail), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule